// File: doc/BRIEF.md
# Power-Up Configuration Loader

This block runs once after every reset. It reads a 256-word by 16-bit nonvolatile store through a synchronous read port. The data for a read comes back exactly one cycle after the read request. The loader first fetches a signature word. If the signature holds the expected value, the loader copies two groups of configuration words into a working register file, using a write strobe with an address and data.

The first group is copied unconditionally. The second group is filtered word by word: a word is copied only when its most significant bit is set. Each copied word goes to the register address equal to its address in the store. When the signature is wrong, nothing is copied and the register file keeps its reset defaults.

While the load runs, `host_hold` tells the register file arbiter to keep host accesses out. When the load finishes, `load_done` rises and stays high until the next reset. `load_applied` then tells whether the copy took place.

The read port is a plain request/response pair and has no back-pressure. The register write port is a one-cycle strobe with no ready signal, so the register file must accept a write on every cycle. There is no write path into the nonvolatile store, so later register writes remain volatile.

Top module: `nvm_cfg_loader`

## Requirements
- R1: While `rst_n` is low (synchronous, active low), `load_done`=0, `load_applied`=0, `reg_wr_en`=0 and `host_hold`=1.
- R2: The first read after reset release is issued with `nvm_rd_addr`=0x37 while reset is released. The load is enabled only if the returned word equals 0xAA55.
- R3: On a signature mismatch, no register write is issued. `load_done` rises on the 2nd rising edge after reset release, and `load_applied` stays 0.
- R4: On a match, every word at 0x10..0x1F is written to the same register address with its stored data, in ascending address order. The data is taken one cycle after its read.
- R5: On a match, after the first group, each word at 0x2C..0x33 is written, in ascending order, only when its bit 15 is 1. Words with bit 15 at 0 produce no write.
- R6: Writes occur only at addresses in the two groups. Each accepted word produces exactly one one-cycle strobe.
- R7: On a match, `load_done` rises on the 28th rising edge after reset release, after the last write strobe, with `load_applied`=1. Once high, `load_done` stays high until reset.
- R8: `host_hold` is 1 exactly while `load_done` is 0. No read is issued and no write is issued once `load_done` is high.
- R9: Asserting reset during a load aborts it. After the next release, the sequence restarts from the signature read, with the same timing and writes as a fresh load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nvm_rd_en | output | 1 | Read request to the nonvolatile store |
| nvm_rd_addr | output | 8 | Read address |
| nvm_rd_data | input | 16 | Read data, valid one cycle after the request |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_wr_addr | output | 8 | Register write address |
| reg_wr_data | output | 16 | Register write data |
| host_hold | output | 1 | High while the loader owns the register file |
| load_done | output | 1 | Sticky completion flag |
| load_applied | output | 1 | High with done when the copy took place |

## Verification
Near-miss signatures (0xAA54, 0x55AA, random values) must bypass the load. A loader that compared only part of the word would issue writes. Filtered-range words are tried with the flag all clear, all set and random. Taking data in the wrong cycle shows up as shifted write data, and ignoring the flag shows up as extra writes. Resets are injected during the signature check and in the middle of the walk. A loader that resumed instead of restarting would give a wrong first read, a wrong completion edge or a short write list.

// File: rtl/nvm_ld_pkg.sv
package nvm_ld_pkg;
  typedef enum logic [2:0] {
    ST_SIG_RD,
    ST_SIG_CHK,
    ST_WALK,
    ST_DRAIN,
    ST_FIN,
    ST_DONE
  } ld_state_e;
endpackage

// File: rtl/nvm_ld_ctrl.sv
module nvm_ld_ctrl
  import nvm_ld_pkg::*;
#(
  parameter int A_LEN = 16,
  parameter int B_LEN = 8,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sig_ok,
  output ld_state_e        st,
  output logic [IDX_W-1:0] idx,
  output logic             applied
);
  localparam int TOTAL = A_LEN + B_LEN;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(TOTAL - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_SIG_RD;
      idx     <= '0;
      applied <= 1'b0;
    end else begin
      case (st)
        ST_SIG_RD:  st <= ST_SIG_CHK;
        ST_SIG_CHK: begin
          idx <= '0;
          if (sig_ok) begin
            applied <= 1'b1;
            st      <= ST_WALK;
          end else begin
            st <= ST_DONE;
          end
        end
        ST_WALK: begin
          if (idx == LAST) st <= ST_DRAIN;
          else             idx <= idx + 1'b1;
        end
        ST_DRAIN: st <= ST_FIN;
        ST_FIN:   st <= ST_DONE;
        ST_DONE:  st <= ST_DONE;
        default:  st <= ST_SIG_RD;
      endcase
    end
  end
endmodule

// File: rtl/nvm_ld_addr.sv
module nvm_ld_addr
  import nvm_ld_pkg::*;
#(
  parameter int              ADDR_W   = 8,
  parameter int              IDX_W    = 5,
  parameter int              A_LEN    = 16,
  parameter int              B_LEN    = 8,
  parameter logic [ADDR_W-1:0] A_BASE   = 8'h10,
  parameter logic [ADDR_W-1:0] B_BASE   = 8'h2C,
  parameter logic [ADDR_W-1:0] SIG_ADDR = 8'h37
) (
  input  ld_state_e         st,
  input  logic [IDX_W-1:0]  idx,
  output logic              rd_en,
  output logic              walk_rd,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              in_b
);
  logic [ADDR_W-1:0] walk_addr;

  generate
    if (B_LEN == 0) begin : g_one_range
      assign in_b      = 1'b0;
      assign walk_addr = A_BASE + ADDR_W'(idx);
    end else begin : g_two_ranges
      logic [IDX_W-1:0] b_off;
      assign in_b      = (idx >= IDX_W'(A_LEN));
      assign b_off     = idx - IDX_W'(A_LEN);
      assign walk_addr = in_b ? (B_BASE + ADDR_W'(b_off)) : (A_BASE + ADDR_W'(idx));
    end
  endgenerate

  assign walk_rd = (st == ST_WALK);
  assign rd_en   = walk_rd || (st == ST_SIG_RD);
  assign rd_addr = (st == ST_SIG_RD) ? SIG_ADDR : walk_addr;
endmodule

// File: rtl/nvm_ld_wr.sv
module nvm_ld_wr #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16,
  parameter int FLAG_BIT = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [ADDR_W-1:0] take_addr,
  input  logic              take_flt,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  logic              pend_v;
  logic              pend_f;
  logic [ADDR_W-1:0] pend_a;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v  <= 1'b0;
      pend_f  <= 1'b0;
      pend_a  <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      pend_v  <= take;
      pend_f  <= take_flt;
      pend_a  <= take_addr;
      wr_en   <= pend_v && (!pend_f || rd_data[FLAG_BIT]);
      wr_addr <= pend_a;
      wr_data <= rd_data;
    end
  end
endmodule

// File: rtl/nvm_cfg_loader.sv
module nvm_cfg_loader
  import nvm_ld_pkg::*;
#(
  parameter int              ADDR_W    = 8,
  parameter int              DATA_W    = 16,
  parameter int              A_LEN     = 16,
  parameter int              B_LEN     = 8,
  parameter logic [ADDR_W-1:0] A_BASE    = 8'h10,
  parameter logic [ADDR_W-1:0] B_BASE    = 8'h2C,
  parameter logic [ADDR_W-1:0] SIG_ADDR  = 8'h37,
  parameter logic [DATA_W-1:0] SIG_VALUE = 16'hAA55,
  parameter int              FLAG_BIT  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              nvm_rd_en,
  output logic [ADDR_W-1:0] nvm_rd_addr,
  input  logic [DATA_W-1:0] nvm_rd_data,
  output logic              reg_wr_en,
  output logic [ADDR_W-1:0] reg_wr_addr,
  output logic [DATA_W-1:0] reg_wr_data,
  output logic              host_hold,
  output logic              load_done,
  output logic              load_applied
);
  localparam int IDX_W = $clog2(A_LEN + B_LEN + 1);

  ld_state_e        st;
  logic [IDX_W-1:0] idx;
  logic             applied_q;
  logic             walk_rd;
  logic             in_b;
  logic             sig_ok;

  assign sig_ok = (nvm_rd_data == SIG_VALUE);

  nvm_ld_ctrl #(.A_LEN(A_LEN), .B_LEN(B_LEN), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sig_ok(sig_ok),
    .st(st), .idx(idx), .applied(applied_q)
  );

  nvm_ld_addr #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .A_LEN(A_LEN), .B_LEN(B_LEN),
    .A_BASE(A_BASE), .B_BASE(B_BASE), .SIG_ADDR(SIG_ADDR)
  ) u_addr (
    .st(st), .idx(idx), .rd_en(nvm_rd_en), .walk_rd(walk_rd),
    .rd_addr(nvm_rd_addr), .in_b(in_b)
  );

  nvm_ld_wr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FLAG_BIT(FLAG_BIT)) u_wr (
    .clk(clk), .rst_n(rst_n), .take(walk_rd), .take_addr(nvm_rd_addr),
    .take_flt(in_b), .rd_data(nvm_rd_data),
    .wr_en(reg_wr_en), .wr_addr(reg_wr_addr), .wr_data(reg_wr_data)
  );

  assign load_done    = (st == ST_DONE);
  assign host_hold    = !load_done;
  assign load_applied = applied_q && load_done;
endmodule

// File: rtl/nvm_cfg_loader_chk.sv
module nvm_cfg_loader_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              nvm_rd_en,
  input logic              reg_wr_en,
  input logic [ADDR_W-1:0] reg_wr_addr,
  input logic [DATA_W-1:0] reg_wr_data,
  input logic              host_hold,
  input logic              load_done,
  input logic              load_applied
);
  logic seen_wr;
  always_ff @(posedge clk) begin
    if (!rst_n)         seen_wr <= 1'b0;
    else if (reg_wr_en) seen_wr <= 1'b1;
  end

  logic in_a, in_b;
  assign in_a = (reg_wr_addr >= 8'h10) && (reg_wr_addr <= 8'h1F);
  assign in_b = (reg_wr_addr >= 8'h2C) && (reg_wr_addr <= 8'h33);

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n) load_done |=> load_done); // R7
  AST_APPLIED_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n) load_applied |-> load_done); // R7
  AST_HOLD_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n) !load_done |-> host_hold); // R8
  AST_RELEASE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n) load_done |-> !host_hold); // R8
  AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n) load_done |-> !nvm_rd_en && !reg_wr_en); // R8
  AST_FLAG_FILTER: assert property (@(posedge clk) disable iff (!rst_n) (reg_wr_en && in_b) |-> reg_wr_data[15]); // R5
  AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) reg_wr_en |-> (in_a || in_b)); // R6
  AST_WR_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n) (reg_wr_en && $past(reg_wr_en)) |-> (reg_wr_addr > $past(reg_wr_addr))); // R4
  AST_BYPASS_NO_WR: assert property (@(posedge clk) disable iff (!rst_n) (load_done && !load_applied) |-> !seen_wr); // R3
endmodule

bind nvm_cfg_loader nvm_cfg_loader_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .nvm_rd_en(nvm_rd_en), .reg_wr_en(reg_wr_en),
  .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data), .host_hold(host_hold),
  .load_done(load_done), .load_applied(load_applied)
);

// File: tb/nvm_cfg_loader_tb_top.sv
module nvm_cfg_loader_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_RANDOM = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        nvm_rd_en;
  logic [7:0]  nvm_rd_addr;
  logic [15:0] nvm_rd_data = '0;
  logic        reg_wr_en;
  logic [7:0]  reg_wr_addr;
  logic [15:0] reg_wr_data;
  logic        host_hold, load_done, load_applied;

  logic [15:0] mem [256];
  int checks = 0, failures = 0, cyc = 0;
  int exp_n, got_n;
  logic [7:0]  exp_a [32];
  logic [15:0] exp_d [32];
  logic [7:0]  got_a [64];
  logic [15:0] got_d [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (nvm_rd_en) nvm_rd_data <= mem[nvm_rd_addr];

  nvm_cfg_loader dut_i (
    .clk(clk), .rst_n(rst_n), .nvm_rd_en(nvm_rd_en), .nvm_rd_addr(nvm_rd_addr),
    .nvm_rd_data(nvm_rd_data), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
    .reg_wr_data(reg_wr_data), .host_hold(host_hold), .load_done(load_done),
    .load_applied(load_applied)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  function automatic bit sig_match();
    return mem[8'h37] == 16'hAA55;
  endfunction

  task automatic build_expected();
    exp_n = 0;
    if (!sig_match()) return;
    for (int a = 8'h10; a <= 8'h1F; a++) begin
      exp_a[exp_n] = 8'(a); exp_d[exp_n] = mem[a]; exp_n++;
    end
    for (int a = 8'h2C; a <= 8'h33; a++) begin
      if (mem[a][15]) begin
        exp_a[exp_n] = 8'(a); exp_d[exp_n] = mem[a]; exp_n++;
      end
    end
  endtask

  // flag_mode: 0 random, 1 all clear, 2 all set
  task automatic fill_mem(input logic [15:0] sig, input int flag_mode);
    for (int i = 0; i < 256; i++) mem[i] = 16'($urandom);
    for (int a = 8'h2C; a <= 8'h33; a++) begin
      if (flag_mode == 1) mem[a][15] = 1'b0;
      if (flag_mode == 2) mem[a][15] = 1'b1;
    end
    mem[8'h37] = sig;
  endtask

  task automatic run_load(input int abort_at);
    int edges;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!load_done && !load_applied && !reg_wr_en && host_hold, "R1",
        "reset outputs {done,applied,wr,hold}",
        {load_done, load_applied, reg_wr_en, host_hold}, 4'b0001);
    build_expected();
    rst_n = 1'b1;
    #1;
    chk(nvm_rd_en && nvm_rd_addr == 8'h37, "R2", "first read address",
        nvm_rd_en ? nvm_rd_addr : 9'h100, 8'h37);
    edges = 0; got_n = 0;
    while (!load_done && edges < 100) begin
      @(posedge clk); edges++;
      @(negedge clk);
      if (abort_at > 0 && edges == abort_at) begin
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(nvm_rd_en && nvm_rd_addr == 8'h37 && !load_done, "R9",
            "restart read address after abort", nvm_rd_addr, 8'h37);
        edges = 0; got_n = 0; abort_at = 0;
        continue;
      end
      if (reg_wr_en && got_n < 64) begin
        got_a[got_n] = reg_wr_addr; got_d[got_n] = reg_wr_data; got_n++;
      end
      if (!load_done)
        chk(host_hold, "R8", "host_hold while loading", host_hold, 1);
    end
    if (sig_match()) begin
      chk(edges == 28, "R7", "done edge after release (match)", edges, 28);
      chk(load_applied, "R7", "applied on match", load_applied, 1);
    end else begin
      chk(edges == 2, "R3", "done edge after release (mismatch)", edges, 2);
      chk(!load_applied, "R3", "applied on mismatch", load_applied, 0);
    end
    chk(got_n == exp_n, "R5", "write count", got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++) begin
      chk(got_a[i] == exp_a[i], "R4", "write address", got_a[i], exp_a[i]);
      chk(got_d[i] == exp_d[i], "R4", "write data", got_d[i], exp_d[i]);
    end
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); @(negedge clk);
      chk(load_done && !host_hold, "R7", "done sticky / hold released",
          {load_done, host_hold}, 2'b10);
      chk(!reg_wr_en && !nvm_rd_en, "R8", "no access after done",
          {reg_wr_en, nvm_rd_en}, 0);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    // directed corner cases
    fill_mem(16'hAA54, 0); run_load(0);   // R3 near miss
    fill_mem(16'h55AA, 0); run_load(0);   // R3 byte swap
    fill_mem(16'hAA55, 1); run_load(0);   // R5 all flags clear
    fill_mem(16'hAA55, 2); run_load(0);   // R5 all flags set
    fill_mem(16'hAA55, 0); run_load(10);  // R9 abort mid walk
    fill_mem(16'hAA55, 0); run_load(1);   // R9 abort at signature check
    fill_mem(16'hAA55, 0); run_load(27);  // R9 abort at last write
    for (int t = 0; t < NUM_RANDOM; t++) begin
      logic [15:0] s;
      int ab;
      s  = ($urandom_range(3) != 0) ? 16'hAA55 : 16'($urandom);
      ab = ($urandom_range(4) == 0) ? int'($urandom_range(1, 27)) : 0;
      fill_mem(s, 0);
      run_load(ab);
    end
    finish_run();
  end
endmodule